// File: doc/BRIEF.md
# Dual-Channel PWM with Per-Register Transfer Status

This peripheral produces pulse-width modulated outputs on independent channels. A simple 32-bit register bus is clocked by the bus clock. The counters that shape the waveforms run on a separate, usually slower, PWM clock. Each channel has four writable registers: a control word, a clock prescaler, a period count and a duty count. Each register value crosses into the PWM clock domain through its own toggle handshake.

Each channel has a status byte with one busy flag per writable register. A flag goes up on the bus write and comes down once the PWM domain has taken the value. Software polls the flag before it writes that register again. While a flag is up, further writes to that register are dropped. New timing values reach the running counters only when the current period ends, so a reconfiguration never produces a truncated or stretched pulse. The address map has room for four channel slots. Only the first `NUM_CH` slots respond.

Top module: `pwm_multi`

## Requirements
- R1: Channel c's registers sit at byte address c*0x10 plus an offset: control at 0x0, prescaler at 0x4, period at 0x8, duty at 0xC. The address must be a multiple of 4. A read returns the stored value on `bus_rdata` one bus clock after the address is presented. The prescaler keeps wdata bits [9:0]. Period and duty keep bits [11:0]. Control keeps only bit 0 (count enable) and bit 2 (pin enable). All other bits read as zero.
- R2: After reset, every register and every status bit reads zero, and all `pwm_out` bits are low.
- R3: Channel c's status byte is read at address 0x40+c, in bits [3:0]. The bits are: 0 control, 1 prescaler, 2 period, 3 duty. A bit reads as set on the first read after an accepted write to that register. It clears once the value has been captured in the PWM domain, which takes at most 4 PWM clocks plus 3 bus clocks.
- R4: A write to a register whose busy bit is set is ignored. The stored value and the value delivered to the PWM domain stay as they were.
- R5: With control = 5, one output period lasts (prescale+1)*(period+1) PWM clock cycles.
- R6: Each period begins with the output high for duty*(prescale+1) PWM cycles, followed by low for the rest of the period. Duty = 0 keeps the output low. Duty above the period value keeps it high. Duty equal to the period value gives the longest high time that still leaves a low phase: a low phase of prescale+1 cycles.
- R7: While control bit 0 or control bit 2 is clear, the channel output is low.
- R8: While the channel runs, new prescaler, period and duty values take effect only from the next period boundary. The period in progress finishes with the old values.
- R9: The following are ignored on writes and read as zero: channel slots at or above `NUM_CH`, status addresses 0x40+c with c at or above `NUM_CH`, and addresses that are not a multiple of 4.
- R10: Channels run independently. Each channel's waveform depends only on its own registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | 32 | Read data for the address of the previous cycle |
| pwm_clk | input | 1 | Counter clock |
| pwm_rst | input | 1 | Synchronous active-high reset, PWM domain |
| pwm_out | output | NUM_CH | Modulated outputs, one per channel |

## Verification
If the request and acknowledge toggles of a handshake become mismatched, the busy bit sticks at one, or it never rises. Either shows on the next status read, within two bus clocks of the write. A value captured twice or not at all shows up later, as a readback or waveform that disagrees with the last accepted write. A counter that loads new limits mid-period, or misses its terminal count, distorts the very period in which the write lands. That period's high or low phase is measured in PWM cycles against the old values, so the error is seen within one period of the write.

// File: rtl/pwm_multi_pkg.sv
`timescale 1ns/1ps
package pwm_multi_pkg;

    localparam int SLOTS   = 4;
    localparam int REGS    = 4;
    localparam int FIELD_W = 12;
    localparam int CTRL_W  = 2;
    localparam int PRE_W   = 10;
    localparam int PER_W   = 12;

    typedef enum logic [1:0] {
        RG_CTRL   = 2'd0,
        RG_PRESC  = 2'd1,
        RG_PERIOD = 2'd2,
        RG_DUTY   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             run;
        logic             drive;
        logic [PRE_W-1:0] presc;
        logic [PER_W-1:0] period;
        logic [PER_W-1:0] duty;
    } ch_cfg_t;

    typedef struct packed {
        logic     hit;
        logic     is_status;
        logic [1:0] ch;
        reg_sel_e sel;
    } bus_dec_t;

    function automatic int reg_width(int sel);
        case (sel)
            0:       return CTRL_W;
            1:       return PRE_W;
            default: return PER_W;
        endcase
    endfunction

    function automatic logic [CTRL_W-1:0] ctrl_pack(logic [31:0] d);
        return {d[2], d[0]};
    endfunction

    function automatic logic [FIELD_W-1:0] ctrl_view(logic [CTRL_W-1:0] f);
        return {{(FIELD_W-3){1'b0}}, f[1], 1'b0, f[0]};
    endfunction

    function automatic bus_dec_t decode(logic [7:0] a, int n_ch);
        bus_dec_t d;
        d.hit       = 1'b0;
        d.is_status = 1'b0;
        d.ch        = a[5:4];
        d.sel       = reg_sel_e'(a[3:2]);
        if (a[7:6] == 2'b00 && a[1:0] == 2'b00 && int'(a[5:4]) < n_ch) begin
            d.hit = 1'b1;
        end else if (a[7:2] == 6'b010000 && int'(a[1:0]) < n_ch) begin
            d.hit       = 1'b1;
            d.is_status = 1'b1;
            d.ch        = a[1:0];
        end
        return d;
    endfunction

endpackage

// File: rtl/pwm_multi_xfer.sv
`timescale 1ns/1ps
module pwm_multi_xfer #(
    parameter int W = 12
) (
    input  logic         bus_clk,
    input  logic         bus_rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic         busy,
    output logic [W-1:0] shadow,
    input  logic         pwm_clk,
    input  logic         pwm_rst,
    output logic [W-1:0] dst
);
    logic req_t, ack_s1, ack_s2;
    logic req_s1, req_s2, req_s3;

    assign busy = req_t ^ ack_s2;

    // bus side: capture and toggle the request only when idle
    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            req_t  <= 1'b0;
            shadow <= '0;
            ack_s1 <= 1'b0;
            ack_s2 <= 1'b0;
        end else begin
            ack_s1 <= req_s3;
            ack_s2 <= ack_s1;
            if (wr && !busy) begin
                shadow <= wdata;
                req_t  <= ~req_t;
            end
        end
    end

    // PWM side: shadow is held steady while the request is outstanding
    always_ff @(posedge pwm_clk) begin
        if (pwm_rst) begin
            req_s1 <= 1'b0;
            req_s2 <= 1'b0;
            req_s3 <= 1'b0;
            dst    <= '0;
        end else begin
            req_s1 <= req_t;
            req_s2 <= req_s1;
            req_s3 <= req_s2;
            if (req_s2 ^ req_s3) dst <= shadow;
        end
    end
endmodule

// File: rtl/pwm_multi_regs.sv
`timescale 1ns/1ps
module pwm_multi_regs
    import pwm_multi_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic        bus_clk,
    input  logic        bus_rst,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic        bus_we,
    output logic [31:0] bus_rdata,
    input  logic        pwm_clk,
    input  logic        pwm_rst,
    output ch_cfg_t [NUM_CH-1:0]                        cfg,
    output logic    [NUM_CH-1:0][REGS-1:0]              busy,
    output logic    [NUM_CH-1:0][REGS-1:0][FIELD_W-1:0] shadow
);
    bus_dec_t    dec;
    logic [31:0] rd_next;

    logic [NUM_CH-1:0]             run_w, drive_w;
    logic [NUM_CH-1:0][PRE_W-1:0]  pre_w;
    logic [NUM_CH-1:0][PER_W-1:0]  per_w, duty_w;
    logic                          unused_wdata_hi;

    assign dec             = decode(bus_addr, NUM_CH);
    assign unused_wdata_hi = ^{bus_wdata[31:12], bus_wdata[1]};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        for (genvar r = 0; r < REGS; r++) begin : g_reg
            localparam int W = reg_width(r);
            logic         wr;
            logic [W-1:0] wval, sh, d;

            assign wr = bus_we && dec.hit && !dec.is_status &&
                        int'(dec.ch) == c && dec.sel == reg_sel_e'(r);

            if (r == 0) begin : g_ctrl
                assign wval         = ctrl_pack(bus_wdata);
                assign shadow[c][r] = ctrl_view(sh);
                assign run_w[c]     = d[0];
                assign drive_w[c]   = d[1];
            end else begin : g_num
                assign wval         = bus_wdata[W-1:0];
                assign shadow[c][r] = FIELD_W'(sh);
                if (r == 1) begin : g_pre
                    assign pre_w[c] = d;
                end else if (r == 2) begin : g_per
                    assign per_w[c] = d;
                end else begin : g_duty
                    assign duty_w[c] = d;
                end
            end

            pwm_multi_xfer #(.W(W)) u_xfer (
                .bus_clk (bus_clk),
                .bus_rst (bus_rst),
                .wr      (wr),
                .wdata   (wval),
                .busy    (busy[c][r]),
                .shadow  (sh),
                .pwm_clk (pwm_clk),
                .pwm_rst (pwm_rst),
                .dst     (d)
            );
        end
    end

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            cfg[c].run    = run_w[c];
            cfg[c].drive  = drive_w[c];
            cfg[c].presc  = pre_w[c];
            cfg[c].period = per_w[c];
            cfg[c].duty   = duty_w[c];
        end
    end

    always_comb begin
        rd_next = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (dec.hit && int'(dec.ch) == c) begin
                if (dec.is_status) rd_next = 32'(busy[c]);
                else               rd_next = 32'(shadow[c][dec.sel]);
            end
        end
    end

    always_ff @(posedge bus_clk) begin
        if (bus_rst) bus_rdata <= '0;
        else         bus_rdata <= rd_next;
    end
endmodule

// File: rtl/pwm_multi_chan.sv
`timescale 1ns/1ps
module pwm_multi_chan
    import pwm_multi_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ch_cfg_t cfg,
    output logic    pwm_o
);
    logic [PRE_W-1:0] pre_a, pc;
    logic [PER_W-1:0] per_a, duty_a, cnt;
    logic             tick, last;

    assign tick = (pc == pre_a);
    assign last = tick && (cnt == per_a);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_a  <= '0;
            per_a  <= '0;
            duty_a <= '0;
            pc     <= '0;
            cnt    <= '0;
            pwm_o  <= 1'b0;
        end else begin
            if (!cfg.run) begin
                // stopped: counters parked, limits follow the staged values
                pc     <= '0;
                cnt    <= '0;
                pre_a  <= cfg.presc;
                per_a  <= cfg.period;
                duty_a <= cfg.duty;
            end else if (last) begin
                pc     <= '0;
                cnt    <= '0;
                pre_a  <= cfg.presc;
                per_a  <= cfg.period;
                duty_a <= cfg.duty;
            end else if (tick) begin
                pc  <= '0;
                cnt <= cnt + 1'b1;
            end else begin
                pc <= pc + 1'b1;
            end
            pwm_o <= cfg.run && cfg.drive && (cnt < duty_a);
        end
    end
endmodule

// File: rtl/pwm_multi.sv
`timescale 1ns/1ps
module pwm_multi
    import pwm_multi_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              bus_clk,
    input  logic              bus_rst,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    output logic [31:0]       bus_rdata,
    input  logic              pwm_clk,
    input  logic              pwm_rst,
    output logic [NUM_CH-1:0] pwm_out
);
    ch_cfg_t [NUM_CH-1:0]                        cfg_vec;
    logic    [NUM_CH-1:0][REGS-1:0]              busy_vec;
    logic    [NUM_CH-1:0][REGS-1:0][FIELD_W-1:0] shadow_vec;

    pwm_multi_regs #(.NUM_CH(NUM_CH)) u_regs (
        .bus_clk   (bus_clk),
        .bus_rst   (bus_rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .pwm_clk   (pwm_clk),
        .pwm_rst   (pwm_rst),
        .cfg       (cfg_vec),
        .busy      (busy_vec),
        .shadow    (shadow_vec)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        pwm_multi_chan u_chan (
            .clk   (pwm_clk),
            .rst   (pwm_rst),
            .cfg   (cfg_vec[c]),
            .pwm_o (pwm_out[c])
        );
    end
endmodule

// File: rtl/pwm_multi_chk.sv
`timescale 1ns/1ps
module pwm_multi_chk
    import pwm_multi_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input logic              bus_clk,
    input logic              bus_rst,
    input logic [7:0]        bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_rdata,
    input logic              pwm_clk,
    input logic              pwm_rst,
    input logic [NUM_CH-1:0] pwm_out,
    input ch_cfg_t [NUM_CH-1:0]                        cfg_vec,
    input logic    [NUM_CH-1:0][REGS-1:0]              busy_vec,
    input logic    [NUM_CH-1:0][REGS-1:0][FIELD_W-1:0] shadow_vec
);
    a_r2_rdata_reset: assert property (@(posedge bus_clk)
        bus_rst |=> bus_rdata == 32'd0);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_c
        for (genvar r = 0; r < REGS; r++) begin : g_r
            a_r3_busy_on_write: assert property (@(posedge bus_clk) disable iff (bus_rst)
                (bus_we && bus_addr == 8'(c*16 + r*4) && !busy_vec[c][r])
                |=> busy_vec[c][r]);

            a_r4_hold_while_busy: assert property (@(posedge bus_clk) disable iff (bus_rst)
                (bus_we && bus_addr == 8'(c*16 + r*4) && busy_vec[c][r])
                |=> $stable(shadow_vec[c][r]));
        end

        a_r7_gate_low: assert property (@(posedge pwm_clk) disable iff (pwm_rst)
            !(cfg_vec[c].run && cfg_vec[c].drive) |=> !pwm_out[c]);

        a_r6_stopped_zero_duty: assert property (@(posedge pwm_clk) disable iff (pwm_rst)
            (!cfg_vec[c].run || cfg_vec[c].duty == '0) && $stable(cfg_vec[c].duty)
            && !cfg_vec[c].run |=> !pwm_out[c]);
    end

    for (genvar s = NUM_CH; s < SLOTS; s++) begin : g_empty
        a_r9_empty_slot: assert property (@(posedge bus_clk) disable iff (bus_rst)
            (bus_addr == 8'(s*16) || bus_addr == 8'(8'h40 + s)) |=> bus_rdata == 32'd0);
    end
endmodule

bind pwm_multi pwm_multi_chk #(.NUM_CH(NUM_CH)) u_chk (
    .bus_clk    (bus_clk),
    .bus_rst    (bus_rst),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_rdata  (bus_rdata),
    .pwm_clk    (pwm_clk),
    .pwm_rst    (pwm_rst),
    .pwm_out    (pwm_out),
    .cfg_vec    (cfg_vec),
    .busy_vec   (busy_vec),
    .shadow_vec (shadow_vec)
);

// File: tb/pwm_multi_test.sv
`timescale 1ns/1ps
module pwm_multi_test;
    localparam int NCH = 2;

    logic            bus_clk = 1'b0;
    logic            pwm_clk = 1'b0;
    logic            bus_rst = 1'b1;
    logic            pwm_rst = 1'b1;
    logic [7:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic            bus_we = 1'b0;
    logic [31:0]     bus_rdata;
    logic [NCH-1:0]  pwm_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 bus_clk = ~bus_clk;   // 250 MHz
    always #5 pwm_clk = ~pwm_clk;   // counter clock

    pwm_multi #(.NUM_CH(NCH)) uut (
        .bus_clk   (bus_clk),
        .bus_rst   (bus_rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .pwm_clk   (pwm_clk),
        .pwm_rst   (pwm_rst),
        .pwm_out   (pwm_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge bus_clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge bus_clk);
        bus_we    = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge bus_clk);
        bus_addr = a;
        bus_we   = 1'b0;
        @(negedge bus_clk);
        d = bus_rdata;
    endtask

    task automatic wait_idle(input logic [7:0] a, output int polls);
        logic [31:0] st;
        logic [7:0]  sa;
        sa    = 8'h40 | {6'b0, a[5:4]};
        polls = 0;
        do begin
            bus_read(sa, st);
            polls++;
        end while (st[a[3:2]] && polls < 100);
    endtask

    task automatic set_reg(input logic [7:0] a, input logic [31:0] d);
        int p;
        bus_write(a, d);
        wait_idle(a, p);
    endtask

    task automatic wait_edge(input int ch, input logic v);
        int guard = 0;
        @(negedge pwm_clk);
        while (pwm_out[ch] == v && guard < 5000) begin @(negedge pwm_clk); guard++; end
        while (pwm_out[ch] != v && guard < 5000) begin @(negedge pwm_clk); guard++; end
    endtask

    task automatic count_level(input int ch, input logic v, input int cap, output int n);
        n = 0;
        while (pwm_out[ch] == v && n < cap) begin
            n++;
            @(negedge pwm_clk);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int c = 0; c < NCH; c++) begin
            for (int r = 0; r < 4; r++) begin
                bus_read(8'(c*16 + r*4), d);
                chk(d == 0, "R2 register after reset", int'(d), 0);
            end
            bus_read(8'(8'h40 + c), d);
            chk(d == 0, "R2 status after reset", int'(d), 0);
        end
        chk(pwm_out == '0, "R2 outputs after reset", int'(pwm_out), 0);
    endtask

    task automatic t_map();
        logic [31:0] d;
        set_reg(8'h04, 32'hFFFF_FFFF);
        bus_read(8'h04, d);
        chk(d == 32'h3FF, "R1 prescaler width", int'(d), 32'h3FF);
        set_reg(8'h08, 32'h000A_BCDE);
        bus_read(8'h08, d);
        chk(d == 32'hCDE, "R1 period width", int'(d), 32'hCDE);
        set_reg(8'h1C, 32'h0000_1234);
        bus_read(8'h1C, d);
        chk(d == 32'h234, "R1 duty slot ch1", int'(d), 32'h234);
        set_reg(8'h10, 32'h0000_00FA);
        bus_read(8'h10, d);
        chk(d == 32'h0, "R1 control keeps bits 0 and 2 (0xFA)", int'(d), 0);
        set_reg(8'h10, 32'h0000_0007);
        bus_read(8'h10, d);
        chk(d == 32'h5, "R1 control keeps bits 0 and 2 (0x7)", int'(d), 5);
        set_reg(8'h10, 32'h0);
    endtask

    task automatic t_busy();
        logic [31:0] d;
        int p;
        bus_write(8'h18, 32'h10);
        bus_read(8'h41, d);
        chk(d == 32'h4, "R3 period busy bit after write", int'(d), 4);
        wait_idle(8'h18, p);
        chk(p <= 8, "R3 busy clears within bound (polls)", p, 8);
        bus_read(8'h41, d);
        chk(d == 32'h0, "R3 status idle", int'(d), 0);
        // two writes in consecutive bus cycles: the second lands while busy
        @(negedge bus_clk);
        bus_addr = 8'h1C; bus_wdata = 32'd7; bus_we = 1'b1;
        @(negedge bus_clk);
        bus_wdata = 32'd9;
        @(negedge bus_clk);
        bus_we = 1'b0;
        bus_read(8'h41, d);
        chk(d == 32'h8, "R3 duty busy bit", int'(d), 8);
        wait_idle(8'h1C, p);
        bus_read(8'h1C, d);
        chk(d == 32'd7, "R4 write during busy ignored", int'(d), 7);
    endtask

    task automatic t_wave();
        int n;
        set_reg(8'h04, 1);
        set_reg(8'h08, 9);
        set_reg(8'h0C, 3);
        set_reg(8'h00, 5);
        wait_edge(0, 1'b1);
        count_level(0, 1'b1, 500, n);
        chk(n == 6, "R6 high time duty*(pre+1)", n, 6);
        count_level(0, 1'b0, 500, n);
        chk(n == 14, "R5 rest of period (total 20)", n, 14);
        set_reg(8'h0C, 9);
        wait_edge(0, 1'b1);
        wait_edge(0, 1'b1);
        count_level(0, 1'b1, 500, n);
        chk(n == 18, "R6 duty equal to period high", n, 18);
        count_level(0, 1'b0, 500, n);
        chk(n == 2, "R6 duty equal to period low", n, 2);
        set_reg(8'h0C, 0);
        repeat (60) @(negedge pwm_clk);
        count_level(0, 1'b0, 60, n);
        chk(n == 60, "R6 zero duty stays low", n, 60);
        set_reg(8'h0C, 10);
        repeat (60) @(negedge pwm_clk);
        count_level(0, 1'b1, 60, n);
        chk(n == 60, "R6 duty above period stays high", n, 60);
    endtask

    task automatic t_gate();
        int n;
        set_reg(8'h00, 1);
        repeat (5) @(negedge pwm_clk);
        count_level(0, 1'b0, 50, n);
        chk(n == 50, "R7 pin enable clear gives low", n, 50);
        set_reg(8'h00, 4);
        repeat (5) @(negedge pwm_clk);
        count_level(0, 1'b0, 50, n);
        chk(n == 50, "R7 count enable clear gives low", n, 50);
        set_reg(8'h00, 0);
    endtask

    task automatic t_boundary();
        int n;
        set_reg(8'h04, 0);
        set_reg(8'h08, 39);
        set_reg(8'h0C, 30);
        set_reg(8'h00, 5);
        wait_edge(0, 1'b1);
        bus_write(8'h0C, 10);
        count_level(0, 1'b1, 500, n);
        chk(n >= 25 && n <= 30, "R8 duty change waits for boundary (high remainder)", n, 28);
        count_level(0, 1'b0, 500, n);
        chk(n == 10, "R8 old period completes", n, 10);
        count_level(0, 1'b1, 500, n);
        chk(n == 10, "R8 new duty after boundary", n, 10);
        wait_edge(0, 1'b1);
        bus_write(8'h08, 19);
        count_level(0, 1'b1, 500, n);
        count_level(0, 1'b0, 500, n);
        chk(n == 30, "R8 period change waits for boundary", n, 30);
        count_level(0, 1'b1, 500, n);
        chk(n == 10, "R8 high after period change", n, 10);
        count_level(0, 1'b0, 500, n);
        chk(n == 10, "R5 new period 20", n, 10);
    endtask

    task automatic t_indep();
        int n;
        set_reg(8'h14, 2);
        set_reg(8'h18, 4);
        set_reg(8'h1C, 2);
        set_reg(8'h10, 5);
        wait_edge(1, 1'b1);
        count_level(1, 1'b1, 500, n);
        chk(n == 6, "R10 ch1 high", n, 6);
        count_level(1, 1'b0, 500, n);
        chk(n == 9, "R10 ch1 low", n, 9);
        wait_edge(0, 1'b1);
        count_level(0, 1'b1, 500, n);
        chk(n == 10, "R10 ch0 unchanged high", n, 10);
        count_level(0, 1'b0, 500, n);
        chk(n == 10, "R10 ch0 unchanged low", n, 10);
    endtask

    task automatic t_unimpl();
        logic [31:0] d;
        bus_write(8'h20, 32'h123);
        bus_read(8'h20, d);
        chk(d == 0, "R9 slot 2 reads zero", int'(d), 0);
        bus_write(8'h3C, 32'h55);
        bus_read(8'h3C, d);
        chk(d == 0, "R9 slot 3 reads zero", int'(d), 0);
        bus_read(8'h42, d);
        chk(d == 0, "R9 status 0x42 reads zero", int'(d), 0);
        bus_write(8'h09, 32'h7);
        bus_read(8'h08, d);
        chk(d == 19, "R9 unaligned write ignored", int'(d), 19);
        bus_read(8'h09, d);
        chk(d == 0, "R9 unaligned read zero", int'(d), 0);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge pwm_clk);
        bus_rst = 1'b0;
        pwm_rst = 1'b0;
        repeat (2) @(negedge bus_clk);
        t_reset();
        t_map();
        t_busy();
        t_wave();
        t_gate();
        t_boundary();
        t_indep();
        t_unimpl();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule